// File: doc/BRIEF.md
# Mode-banked register file

This block is the general-purpose register storage of a 32-bit core with sixteen architectural registers, r0 to r15, plus the current status word and one saved-status word for each privileged exception bank. A 5-bit processor mode picks the bank of physical copies behind each architectural index. A fixed 32-entry map turns each mode value into a bank. The fast-interrupt bank has its own r8 to r14. The interrupt, supervisor, abort and undefined banks have their own r13 and r14 only. The system bank uses the user copies. Any mode value outside the map selects a dummy bank, whose r8 to r14 read as zero.

Every read port and the write port carries its own mode input, so the core can reach any mode's copies, not only the live ones. A caller that wants the live registers drives the `cur_mode` output back into the mode input. Banking is done by physical indexing. A mode change made through a status write therefore takes effect on the next cycle without any copy phase. Status writes carry a byte-enable mask. In the user modes only the flag byte can change. In the other modes the mode byte can change as well, and that is how the core switches mode.

Top module: `rbf_banked_regfile`

## Requirements
- R1: Modes 0 and 16 map to the user bank, 1 and 17 to fast-interrupt, 2 and 18 to interrupt, 3 and 19 to supervisor, 23 to abort, 27 to undefined and 31 to system. Every other mode value maps to the dummy bank.
- R2: r0 to r7 and r15 have one physical copy each, shared by every mode including the dummy bank.
- R3: The fast-interrupt bank has private r8 to r14. The interrupt, supervisor, abort and undefined banks have private r13 and r14 and share r8 to r12 with user. The system bank uses the user r13 and r14.
- R4: Through the dummy bank, r8 to r14 read as zero and writes to them are dropped. The user copies of those registers keep their values.
- R5: Each read port returns, combinationally, the register `rd_idx` of the bank of `rd_mode`. A write is seen by reads from the next cycle on. A read in the same cycle as the write returns the old value.
- R6: The write port updates register `wr_idx` in the bank of `wr_mode`. A status write that changes the mode field (bits 4:0) shows on `cur_mode` one cycle later.
- R7: After reset, every register and saved-status word is zero and the status word is 0x0000_0013 (supervisor).
- R8: A status write (`st_saved`=0) replaces the bytes enabled in `st_mask`: bit 3 for bits 31:24, bit 2 for 23:16, bit 1 for 15:8 and bit 0 for 7:0. In the user modes (0 and 16) only bit 3 has any effect.
- R9: A saved-status write (`st_saved`=1) goes, byte-masked as in R8, to the saved word of the current bank. If that bank has no saved word (user, system or dummy), the write has no effect.
- R10: `sr_rdata` gives the saved word of the bank of `sr_mode`. For a bank without a saved word it gives the current status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_mode | input | NUM_RD x 5 | Mode whose bank each read port addresses |
| rd_idx | input | NUM_RD x 4 | Architectural register index for each read port |
| rd_data | output | NUM_RD x DATA_W | Read data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_mode | input | 5 | Mode whose bank the write addresses |
| wr_idx | input | 4 | Architectural register index to write |
| wr_data | input | DATA_W | Write data |
| st_we | input | 1 | Status write enable |
| st_saved | input | 1 | 1 targets the current bank's saved word, 0 the status word |
| st_mask | input | DATA_W/8 | Byte enables for the status write |
| st_wdata | input | DATA_W | Status write data |
| sr_mode | input | 5 | Mode whose saved word is read |
| sr_rdata | output | DATA_W | Saved-status read data |
| status_word | output | DATA_W | Current status word |
| cur_mode | output | 5 | Current mode, bits 4:0 of the status word |

## Verification
The assertions expect every control input to be known, never X, once reset is released. They also expect a mode input to be any 5-bit value, since the block gives every code a defined meaning. The bench drives all inputs on the falling edge, from reset onward, and changes them only there. Mode stimulus mixes the eleven mapped codes with arbitrary 5-bit values, so dummy-bank accesses and unmapped mode switches occur next to ordinary traffic. Periodic resets pull the core out of the user modes, which a status write cannot leave.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

   localparam int unsigned MODE_W      = 5;
   localparam int unsigned IDX_W       = 4;
   localparam int unsigned NSAVED      = 5;
   // physical slot layout: r0..r7 at 0..7, user r8..r12 at 8..12,
   // fast-interrupt r8..r12 at 13..17, six r13/r14 pairs from 18, r15 last
   localparam int unsigned SLOT_FIQ_LO = 13;
   localparam int unsigned SLOT_HI     = 18;
   localparam int unsigned SLOT_PC     = 30;
   localparam int unsigned NSLOT       = 31;
   localparam int unsigned SLOT_W      = $clog2(NSLOT);

   typedef enum logic [2:0] {
      BK_USR = 3'd0,
      BK_FIQ = 3'd1,
      BK_IRQ = 3'd2,
      BK_SVC = 3'd3,
      BK_ABT = 3'd4,
      BK_UND = 3'd5,
      BK_SYS = 3'd6,
      BK_DUM = 3'd7
   } bank_e;

   typedef struct packed {
      logic [SLOT_W-1:0] slot;
      logic              zero;
   } loc_t;

   function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
      if (m[3:2] == 2'b00) return bank_e'({1'b0, m[1:0]});
      case (m)
         5'd23:   return BK_ABT;
         5'd27:   return BK_UND;
         5'd31:   return BK_SYS;
         default: return BK_DUM;
      endcase
   endfunction

   function automatic logic has_saved(input bank_e b);
      return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
             (b == BK_ABT) || (b == BK_UND);
   endfunction

   function automatic loc_t locate(input bank_e b, input logic [IDX_W-1:0] idx);
      loc_t        l;
      int unsigned pair;
      l.zero = 1'b0;
      l.slot = '0;
      pair   = (b == BK_SYS) ? 0 : 32'(b);
      if (idx < 4'd8)
         l.slot = SLOT_W'(idx);
      else if (idx == 4'd15)
         l.slot = SLOT_W'(SLOT_PC);
      else if (b == BK_DUM)
         l.zero = 1'b1;
      else if (idx <= 4'd12)
         l.slot = (b == BK_FIQ) ? SLOT_W'(SLOT_FIQ_LO + 32'(idx) - 8) : SLOT_W'(idx);
      else
         l.slot = SLOT_W'(SLOT_HI + 2 * pair + 32'(idx) - 13);
      return l;
   endfunction

endpackage

// File: rtl/rbf_locate.sv
module rbf_locate
   import rbf_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic [IDX_W-1:0]  idx,
   output logic [SLOT_W-1:0] slot,
   output logic              zero
);
   loc_t l;

   always_comb begin
      l    = locate(mode_to_bank(mode), idx);
      slot = l.slot;
      zero = l.zero;
   end
endmodule

// File: rtl/rbf_gpr_store.sv
module rbf_gpr_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NSLOT  = 31,
   parameter int unsigned SLOT_W = 5,
   parameter int unsigned NUM_RD = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [SLOT_W-1:0]              wslot,
   input  logic [DATA_W-1:0]              wdata,
   input  logic [NUM_RD-1:0][SLOT_W-1:0]  rslot,
   input  logic [NUM_RD-1:0]              rzero,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);
   logic [DATA_W-1:0] mem_q [NSLOT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(NSLOT); s++) mem_q[s] <= '0;
      end else if (we) begin
         mem_q[wslot] <= wdata;
      end
   end

   for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
      assign rdata[g] = rzero[g] ? '0 : mem_q[rslot[g]];
   end

   // R5: an accepted write is held by its slot on the next cycle
   assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem_q[$past(wslot)] == $past(wdata));
endmodule

// File: rtl/rbf_status.sv
module rbf_status
   import rbf_pkg::*;
#(
   parameter int unsigned       DATA_W     = 32,
   parameter logic [MODE_W-1:0] RESET_MODE = 5'h13
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  st_we,
   input  logic                  st_saved,
   input  logic [DATA_W/8-1:0]   st_mask,
   input  logic [DATA_W-1:0]     st_wdata,
   input  logic [MODE_W-1:0]     sr_mode,
   output logic [DATA_W-1:0]     sr_rdata,
   output logic [DATA_W-1:0]     cpsr_q
);
   localparam int unsigned NBYTE = DATA_W / 8;

   function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                               input logic [DATA_W-1:0] new_v,
                                               input logic [NBYTE-1:0]  en);
      logic [DATA_W-1:0] r;
      r = old_v;
      for (int k = 0; k < int'(NBYTE); k++)
         if (en[k]) r[k*8 +: 8] = new_v[k*8 +: 8];
      return r;
   endfunction

   bank_e                          cur_bank;
   bank_e                          sr_bank;
   logic [NBYTE-1:0]               cmask;
   logic [NSAVED-1:0][DATA_W-1:0]  saved_all;

   assign cur_bank = mode_to_bank(cpsr_q[MODE_W-1:0]);
   assign sr_bank  = mode_to_bank(sr_mode);
   assign cmask    = (cur_bank == BK_USR) ? {st_mask[NBYTE-1], {(NBYTE-1){1'b0}}} : st_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cpsr_q <= DATA_W'(RESET_MODE);
      else if (st_we && !st_saved) cpsr_q <= merge(cpsr_q, st_wdata, cmask);
   end

   for (genvar g = 0; g < NSAVED; g++) begin : g_saved
      localparam bank_e OWNER = bank_e'(3'(g + 1));
      logic [DATA_W-1:0] sv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     sv_q <= '0;
         else if (st_we && st_saved && cur_bank == OWNER) sv_q <= merge(sv_q, st_wdata, st_mask);
      end
      assign saved_all[g] = sv_q;
   end

   assign sr_rdata = has_saved(sr_bank) ? saved_all[3'(sr_bank) - 3'd1] : cpsr_q;

   // R8: in a user mode only the flag byte of the status word may move
   assert_user_flags_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && !st_saved && cur_bank == BK_USR)
      |=> cpsr_q[DATA_W-9:0] == $past(cpsr_q[DATA_W-9:0]));

   // R9: saved write from a bank without a saved word leaves all saved words
   assert_saved_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && st_saved && !has_saved(cur_bank)) |=> $stable(saved_all));

   // R6: a privileged control-byte write sets the mode on the next cycle
   assert_mode_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && !st_saved && cur_bank != BK_USR && st_mask[0])
      |=> cpsr_q[MODE_W-1:0] == $past(st_wdata[MODE_W-1:0]));
endmodule

// File: rtl/rbf_banked_regfile.sv
module rbf_banked_regfile
   import rbf_pkg::*;
#(
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       NUM_RD     = 2,
   parameter logic [4:0]        RESET_MODE = 5'h13
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_RD-1:0][4:0]         rd_mode,
   input  logic [NUM_RD-1:0][3:0]         rd_idx,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
   input  logic                           wr_en,
   input  logic [4:0]                     wr_mode,
   input  logic [3:0]                     wr_idx,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic                           st_we,
   input  logic                           st_saved,
   input  logic [DATA_W/8-1:0]            st_mask,
   input  logic [DATA_W-1:0]              st_wdata,
   input  logic [4:0]                     sr_mode,
   output logic [DATA_W-1:0]              sr_rdata,
   output logic [DATA_W-1:0]              status_word,
   output logic [4:0]                     cur_mode
);
   if (DATA_W != 32) begin : g_bad_width
      $error("rbf_banked_regfile: DATA_W must be 32 for the status byte layout");
   end
   if (NUM_RD < 1) begin : g_bad_ports
      $error("rbf_banked_regfile: NUM_RD must be at least 1");
   end
   if (mode_to_bank(RESET_MODE) == BK_DUM) begin : g_bad_reset
      $error("rbf_banked_regfile: RESET_MODE must map to a real bank");
   end

   logic [NUM_RD-1:0][SLOT_W-1:0] rd_slot;
   logic [NUM_RD-1:0]             rd_zero;
   logic [SLOT_W-1:0]             w_slot;
   logic                          w_zero;
   logic [DATA_W-1:0]             cpsr;

   for (genvar g = 0; g < NUM_RD; g++) begin : g_rloc
      rbf_locate i_loc (
         .mode (rd_mode[g]),
         .idx  (rd_idx[g]),
         .slot (rd_slot[g]),
         .zero (rd_zero[g])
      );

      // R4: any dummy-bank read of r8..r14 returns zero
      assert_dummy_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_to_bank(rd_mode[g]) == BK_DUM && rd_idx[g] >= 4'd8 && rd_idx[g] <= 4'd14)
         |-> rd_data[g] == '0);
   end

   rbf_locate i_wloc (
      .mode (wr_mode),
      .idx  (wr_idx),
      .slot (w_slot),
      .zero (w_zero)
   );

   rbf_gpr_store #(
      .DATA_W (DATA_W),
      .NSLOT  (NSLOT),
      .SLOT_W (SLOT_W),
      .NUM_RD (NUM_RD)
   ) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && !w_zero),
      .wslot (w_slot),
      .wdata (wr_data),
      .rslot (rd_slot),
      .rzero (rd_zero),
      .rdata (rd_data)
   );

   rbf_status #(
      .DATA_W     (DATA_W),
      .RESET_MODE (RESET_MODE)
   ) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_we    (st_we),
      .st_saved (st_saved),
      .st_mask  (st_mask),
      .st_wdata (st_wdata),
      .sr_mode  (sr_mode),
      .sr_rdata (sr_rdata),
      .cpsr_q   (cpsr)
   );

   assign status_word = cpsr;
   assign cur_mode    = cpsr[4:0];
endmodule

// File: tb/test_rbf_banked_regfile.sv
module test_rbf_banked_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int NRD        = 2;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [NRD-1:0][4:0]   rd_mode;
   logic [NRD-1:0][3:0]   rd_idx;
   logic [NRD-1:0][31:0]  rd_data;
   logic                  wr_en;
   logic [4:0]            wr_mode;
   logic [3:0]            wr_idx;
   logic [31:0]           wr_data;
   logic                  st_we;
   logic                  st_saved;
   logic [3:0]            st_mask;
   logic [31:0]           st_wdata;
   logic [4:0]            sr_mode;
   logic [31:0]           sr_rdata;
   logic [31:0]           status_word;
   logic [4:0]            cur_mode;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rbf_banked_regfile #(.DATA_W(32), .NUM_RD(NRD), .RESET_MODE(5'h13)) i_rbf_banked_regfile (
      .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .rd_idx(rd_idx), .rd_data(rd_data),
      .wr_en(wr_en), .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_data(wr_data),
      .st_we(st_we), .st_saved(st_saved), .st_mask(st_mask), .st_wdata(st_wdata),
      .sr_mode(sr_mode), .sr_rdata(sr_rdata), .status_word(status_word), .cur_mode(cur_mode)
   );

   // ---------------- behavioural reference ----------------
   logic [31:0] m_gen [0:15];          // user view of all sixteen
   logic [31:0] m_fiq [8:14];
   logic [31:0] m_hi  [2:5][13:14];    // irq, svc, abort, undefined
   logic [31:0] m_cpsr;
   logic [31:0] m_spsr [1:5];

   // 0 user, 1 fiq, 2 irq, 3 svc, 4 abort, 5 undefined, 6 system, 7 dummy
   function automatic int bk(input logic [4:0] m);
      case (m)
         5'd0, 5'd16:  return 0;
         5'd1, 5'd17:  return 1;
         5'd2, 5'd18:  return 2;
         5'd3, 5'd19:  return 3;
         5'd23:        return 4;
         5'd27:        return 5;
         5'd31:        return 6;
         default:      return 7;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input logic [4:0] m, input logic [3:0] ix);
      int b = bk(m);
      int i = int'(ix);
      if (i < 8 || i == 15) return m_gen[i];
      if (b == 7)           return 32'h0;
      if (b == 1)           return m_fiq[i];
      if (i < 13 || b == 0 || b == 6) return m_gen[i];
      return m_hi[b][i];
   endfunction

   task automatic m_write(input logic [4:0] m, input logic [3:0] ix, input logic [31:0] d);
      int b = bk(m);
      int i = int'(ix);
      if (i < 8 || i == 15)                 m_gen[i] = d;
      else if (b == 7)                      ;
      else if (b == 1)                      m_fiq[i] = d;
      else if (i < 13 || b == 0 || b == 6)  m_gen[i] = d;
      else                                  m_hi[b][i] = d;
   endtask

   function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] e);
      logic [31:0] r = o;
      for (int k = 0; k < 4; k++) if (e[k]) r[k*8 +: 8] = n[k*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] m_sr(input logic [4:0] m);
      int b = bk(m);
      if (b >= 1 && b <= 5) return m_spsr[b];
      return m_cpsr;
   endfunction

   function automatic string rtag(input logic [4:0] m, input logic [3:0] ix);
      if (ix < 4'd8 || ix == 4'd15) return "R2 shared register";
      if (bk(m) == 7)               return "R4 dummy bank";
      return "R3 banked register";
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 16; i++) m_gen[i] = '0;
      for (int i = 8; i < 15; i++) m_fiq[i] = '0;
      for (int b = 2; b < 6; b++) begin m_hi[b][13] = '0; m_hi[b][14] = '0; end
      for (int b = 1; b < 6; b++) m_spsr[b] = '0;
      m_cpsr = 32'h0000_0013;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int cb;
         cb = bk(m_cpsr[4:0]);
         if (wr_en) m_write(wr_mode, wr_idx, wr_data);
         if (st_we) begin
            if (st_saved) begin
               if (cb >= 1 && cb <= 5) m_spsr[cb] = mrg(m_spsr[cb], st_wdata, st_mask);
            end else begin
               m_cpsr = mrg(m_cpsr, st_wdata, (cb == 0) ? {st_mask[3], 3'b000} : st_mask);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n && !done) begin
         for (int p = 0; p < NRD; p++)
            chk(rtag(rd_mode[p], rd_idx[p]), rd_data[p], m_read(rd_mode[p], rd_idx[p]));
         chk("R8 status word", status_word, m_cpsr);
         chk("R6 current mode", {27'b0, cur_mode}, {27'b0, m_cpsr[4:0]});
         chk("R10 saved read", sr_rdata, m_sr(sr_mode));
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle();
      wr_en = 1'b0; wr_mode = 5'h13; wr_idx = '0; wr_data = '0;
      st_we = 1'b0; st_saved = 1'b0; st_mask = '0; st_wdata = '0;
   endtask

   task automatic set_mode(input logic [4:0] m);
      @(negedge clk); idle();
      st_we = 1'b1; st_mask = 4'b0001; st_wdata = {27'b0, m};
   endtask

   function automatic logic [4:0] pick_mode();
      case ($urandom % 14)
         0: return 5'd0;   1: return 5'd16;  2: return 5'd1;  3: return 5'd17;
         4: return 5'd2;   5: return 5'd18;  6: return 5'd3;  7: return 5'd19;
         8: return 5'd23;  9: return 5'd27;  10: return 5'd31;
         default: return 5'($urandom);
      endcase
   endfunction

   // which r14 copy a mode reaches: system folds onto user
   function automatic int copy_of(input int m);
      int b = bk(5'(m));
      return (b == 6) ? 0 : b;
   endfunction

   initial begin
      rd_mode = {5'h13, 5'h13}; rd_idx = '0; sr_mode = 5'h13;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #3;
      chk("R7 reset status word", status_word, 32'h0000_0013);
      chk("R7 reset mode", {27'b0, cur_mode}, 32'h13);
      chk("R7 reset register", rd_data[0], 32'h0);

      // R5: same-cycle read sees old value, next cycle sees new
      @(negedge clk); idle();
      rd_mode[0] = 5'h13; rd_idx[0] = 4'd3;
      wr_en = 1'b1; wr_mode = 5'h13; wr_idx = 4'd3; wr_data = 32'hCAFE_0003;
      #3; chk("R5 same-cycle read old", rd_data[0], 32'h0);
      @(negedge clk); idle();
      #3; chk("R5 next-cycle read new", rd_data[0], 32'hCAFE_0003);

      // R6: switch to fast-interrupt while writing supervisor r13
      @(negedge clk); idle();
      wr_en = 1'b1; wr_mode = 5'h13; wr_idx = 4'd13; wr_data = 32'h0005_0013;
      st_we = 1'b1; st_mask = 4'b0001; st_wdata = 32'h11;
      #3; chk("R6 mode unchanged in write cycle", {27'b0, cur_mode}, 32'h13);
      @(negedge clk); idle();
      rd_mode[0] = 5'h11; rd_idx[0] = 4'd13; rd_mode[1] = 5'h13; rd_idx[1] = 4'd13;
      #3;
      chk("R6 mode switched next cycle", {27'b0, cur_mode}, 32'h11);
      chk("R3 fast-interrupt r13 private", rd_data[0], 32'h0);
      chk("R3 supervisor r13 kept", rd_data[1], 32'h0005_0013);

      // R3: r8 split between fast-interrupt and the rest; system uses user r13
      @(negedge clk); idle(); wr_en = 1'b1; wr_mode = 5'h11; wr_idx = 4'd8; wr_data = 32'hF1F1_0008;
      @(negedge clk); idle(); wr_en = 1'b1; wr_mode = 5'h10; wr_idx = 4'd8; wr_data = 32'hAAAA_0008;
      @(negedge clk); idle(); wr_en = 1'b1; wr_mode = 5'h1F; wr_idx = 4'd13; wr_data = 32'h5151_0013;
      @(negedge clk); idle();
      rd_mode[0] = 5'h12; rd_idx[0] = 4'd8; rd_mode[1] = 5'h11; rd_idx[1] = 4'd8;
      #3;
      chk("R3 interrupt r8 shares user", rd_data[0], 32'hAAAA_0008);
      chk("R3 fast-interrupt r8 private", rd_data[1], 32'hF1F1_0008);
      @(negedge clk); idle();
      rd_mode[0] = 5'h10; rd_idx[0] = 4'd13;
      #3; chk("R3 system r13 is user r13", rd_data[0], 32'h5151_0013);

      // R1: write r14 through every mode, then read back per mode
      for (int m = 0; m < 32; m++) begin
         @(negedge clk); idle();
         wr_en = 1'b1; wr_mode = 5'(m); wr_idx = 4'd14; wr_data = 32'h1400 + m;
      end
      for (int m = 0; m < 32; m++) begin
         logic [31:0] e;
         e = 32'h0;
         if (copy_of(m) != 7)
            for (int k = 0; k < 32; k++) if (copy_of(k) == copy_of(m)) e = 32'h1400 + k;
         @(negedge clk); idle();
         rd_mode[0] = 5'(m); rd_idx[0] = 4'd14;
         #3; chk("R1 mode to bank map", rd_data[0], e);
      end

      // R4: dummy bank reads zero, drops writes, leaves user copies
      @(negedge clk); idle(); wr_en = 1'b1; wr_mode = 5'h10; wr_idx = 4'd9; wr_data = 32'h9999_0009;
      set_mode(5'h05);
      @(negedge clk); idle();
      wr_en = 1'b1; wr_mode = 5'h05; wr_idx = 4'd9; wr_data = 32'hDEAD_0009;
      rd_mode[0] = 5'h05; rd_idx[0] = 4'd9; rd_mode[1] = 5'h05; rd_idx[1] = 4'd14;
      #3;
      chk("R4 dummy r9 reads zero", rd_data[0], 32'h0);
      chk("R4 dummy r14 reads zero", rd_data[1], 32'h0);
      @(negedge clk); idle();
      rd_mode[0] = 5'h10; rd_idx[0] = 4'd9; rd_mode[1] = 5'h05; rd_idx[1] = 4'd3;
      #3;
      chk("R4 user r9 intact after dummy write", rd_data[0], 32'h9999_0009);
      chk("R2 low register visible in dummy", rd_data[1], 32'hCAFE_0003);
      set_mode(5'h13);

      // R9 / R10: saved-status writes and reads
      @(negedge clk); idle(); st_we = 1'b1; st_saved = 1'b1; st_mask = 4'b1111; st_wdata = 32'h8000_0010;
      @(negedge clk); idle(); sr_mode = 5'h13;
      #3; chk("R9 supervisor saved word written", sr_rdata, 32'h8000_0010);
      @(negedge clk); idle(); sr_mode = 5'h10;
      #3; chk("R10 user has no saved word", sr_rdata, status_word);
      set_mode(5'h1F);
      @(negedge clk); idle(); st_we = 1'b1; st_saved = 1'b1; st_mask = 4'b1111; st_wdata = 32'h1234_5678;
      @(negedge clk); idle(); sr_mode = 5'h13;
      #3; chk("R9 saved write ignored in system", sr_rdata, 32'h8000_0010);
      @(negedge clk); idle(); sr_mode = 5'h1F;
      #3; chk("R10 system reads status word", sr_rdata, 32'h0000_001F);
      set_mode(5'h13);
      @(negedge clk); idle(); st_we = 1'b1; st_saved = 1'b1; st_mask = 4'b0100; st_wdata = 32'h00AB_0000;
      @(negedge clk); idle(); sr_mode = 5'h13;
      #3; chk("R9 byte-masked saved write", sr_rdata, 32'h80AB_0010);

      // R8: privileged full write then user flag-only write
      @(negedge clk); idle(); st_we = 1'b1; st_mask = 4'b1111; st_wdata = 32'h4000_0010;
      @(negedge clk); idle();
      #3; chk("R8 privileged full write", status_word, 32'h4000_0010);
      @(negedge clk); idle(); st_we = 1'b1; st_mask = 4'b1111; st_wdata = 32'hF0FF_FF13;
      @(negedge clk); idle();
      #3; chk("R8 user writes flags only", status_word, 32'hF000_0010);

      // mixed traffic with periodic reset
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         if (c % 500 == 0) begin
            rst_n = 1'b0; idle();
            @(negedge clk);
            rst_n = 1'b1;
         end
         idle();
         for (int p = 0; p < NRD; p++) begin
            rd_mode[p] = pick_mode(); rd_idx[p] = 4'($urandom);
         end
         sr_mode  = pick_mode();
         wr_en    = 1'($urandom);
         wr_mode  = pick_mode();
         wr_idx   = 4'($urandom);
         wr_data  = $urandom;
         st_we    = ($urandom % 6) == 0;
         st_saved = 1'($urandom);
         st_mask  = 4'($urandom);
         st_wdata = {27'($urandom), pick_mode()};
      end

      @(negedge clk); idle();
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule